// File: doc/BRIEF.md
# DMA Channel Address and Count Sequencer

This block is the address and count engine of one DMA channel. Software programs a source address, a destination address, a transfer count, a block size and a control word. When a transfer request arrives, the sequencer copies the programmed addresses and count into a private working set. Every access of the block then uses that working set, and the working address steps after each access.

The programmer-visible registers are updated only at block boundaries. In the cycle after the last access of a block completes, the working addresses and the decremented count are committed. Two-cycle mode reads at the source and then writes at the destination. Fly-by mode issues one access per unit at the destination address and leaves the source untouched. Its direction bit picks a write (I/O to memory) or a read (memory to I/O).

When the count expires, the channel either stops with a completion code or reloads its count and waits for the next request. Stops and errors end the channel with their own 3-bit code. One request runs exactly one block.

Top module: `dma_chan_seq`

## Requirements
- R1: After reset, all visible registers, the control word and the end code are zero, `busy` is low and no access is issued.
- R2: A request seen while the channel is enabled and the end code is 0 copies the visible registers into the working set. In two-cycle mode, accesses alternate between a read (`acc_write`=0) at the working source and a write (`acc_write`=1) at the working destination, starting with the read.
- R3: After each completed access, the address just used steps by its own mode: 0 or 3 hold, 1 increments, 2 decrements. Source and destination modes are independent. The step is 1, 2 or 4 bytes for size codes 0, 1 and 2, and it wraps modulo 2^32.
- R4: The visible source, destination and count registers stay unchanged while `busy` is high. They take the working values in the cycle after the final access of the block completes.
- R5: In fly-by mode (control bit 1), every access uses the working destination address and `acc_write` equals control bit 2. The source register keeps its value, whatever the source mode.
- R6: The count register drops by one per completed block, not per access. A block is `block size` accesses in fly-by mode and 2×`block size` accesses in two-cycle mode.
- R7: When a block brings the count to zero with reload off (control bit 9 = 0), the count reads 0, the end code becomes 3'b001 and the enable (control bit 0) clears.
- R8: When a block brings the count to zero with reload on, the count takes the value last written to the count register, the end code stays 0, the enable stays set and the channel waits for a new request.
- R9: Stops end the channel with a code and clear the enable. `acc_err` together with `acc_done` gives 3'b010, `ext_stop` gives 3'b011 and `sw_stop` gives 3'b100, with that priority. No access follows a stop, and there is no write-back.
- R10: While the enable is clear or the end code is non-zero, requests start no access. Writing the control word (select 4) clears the end code. The selects are 0 source, 1 destination, 2 count (which also sets the reload value) and 3 block size. The control fields are: bit 0 enable, bit 1 fly-by, bit 2 fly-by write, bits 4:3 source mode, bits 6:5 destination mode, bits 8:7 size, bit 9 reload.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| cfg_we | input | 1 | Register write strobe |
| cfg_sel | input | 3 | Register select |
| cfg_wdata | input | AW | Register write data |
| req | input | 1 | Transfer request |
| ext_stop | input | 1 | External stop request |
| sw_stop | input | 1 | Software stop request |
| acc_done | input | 1 | Current access completes this cycle |
| acc_err | input | 1 | Completing access reports an address error |
| acc_valid | output | 1 | Access requested |
| acc_write | output | 1 | Access is a write |
| acc_addr | output | AW | Access address |
| acc_size | output | 2 | Access size code |
| src_q | output | AW | Visible source address |
| dst_q | output | AW | Visible destination address |
| cnt_q | output | CW | Visible transfer count |
| chan_en | output | 1 | Channel enable |
| end_code | output | 3 | End status |
| busy | output | 1 | Block in progress |

## Verification
The properties assume that software writes no register while a block is in flight. The stimulus therefore writes configuration only while `busy` is low. They also assume that the block size and count are at least one, and the stimulus always programs them that way. The access port holds `acc_done` high in every sweep, so each access finishes in one cycle and the expected address sequence follows arithmetically. The stop cases lower `acc_done` to freeze an access while a stop is raised.

// File: rtl/dma_chan_seq.sv
module dma_chan_seq #(
  parameter int AW = 32,
  parameter int CW = 16,
  parameter int BW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          cfg_we,
  input  logic [2:0]    cfg_sel,
  input  logic [AW-1:0] cfg_wdata,
  input  logic          req,
  input  logic          ext_stop,
  input  logic          sw_stop,
  input  logic          acc_done,
  input  logic          acc_err,
  output logic          acc_valid,
  output logic          acc_write,
  output logic [AW-1:0] acc_addr,
  output logic [1:0]    acc_size,
  output logic [AW-1:0] src_q,
  output logic [AW-1:0] dst_q,
  output logic [CW-1:0] cnt_q,
  output logic          chan_en,
  output logic [2:0]    end_code,
  output logic          busy
);
  typedef enum logic [1:0] {S_IDLE, S_RUN, S_WB} st_t;

  st_t           st;
  logic [AW-1:0] wsrc, wdst;
  logic [CW-1:0] rld_r, wcnt;
  logic [BW-1:0] blk_r, bcnt;
  logic [9:0]    ctl_r;
  logic          phase;

  function automatic logic [AW-1:0] nxt(input logic [AW-1:0] a, input logic [1:0] m,
                                        input logic [1:0] sz);
    logic [AW-1:0] d;
    d = (sz == 2'd0) ? AW'(1) : (sz == 2'd1) ? AW'(2) : AW'(4);
    case (m)
      2'd1:    return a + d;
      2'd2:    return a - d;
      default: return a;
    endcase
  endfunction

  wire fly      = ctl_r[1];
  wire use_dst  = fly | phase;
  wire last_acc = fly | phase;
  wire blk_end  = last_acc && (bcnt == blk_r - BW'(1));
  wire [CW-1:0] cnt_next = wcnt - CW'(1);

  wire err_hit  = (st == S_RUN) && acc_done && acc_err;
  wire stop_hit = ctl_r[0] && (st != S_WB) && (err_hit || ext_stop || sw_stop);
  wire [2:0] stop_code = err_hit ? 3'b010 : ext_stop ? 3'b011 : 3'b100;

  assign acc_valid = (st == S_RUN);
  assign acc_addr  = use_dst ? wdst : wsrc;
  assign acc_write = fly ? ctl_r[2] : phase;
  assign acc_size  = ctl_r[8:7];
  assign busy      = (st != S_IDLE);
  assign chan_en   = ctl_r[0];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st       <= S_IDLE;
      src_q    <= '0;
      dst_q    <= '0;
      cnt_q    <= '0;
      rld_r    <= '0;
      blk_r    <= '0;
      ctl_r    <= '0;
      end_code <= '0;
      wsrc     <= '0;
      wdst     <= '0;
      wcnt     <= '0;
      bcnt     <= '0;
      phase    <= 1'b0;
    end else begin
      if (cfg_we) begin
        case (cfg_sel)
          3'd0: src_q <= cfg_wdata;
          3'd1: dst_q <= cfg_wdata;
          3'd2: begin
            cnt_q <= cfg_wdata[CW-1:0];
            rld_r <= cfg_wdata[CW-1:0];
          end
          3'd3: blk_r <= cfg_wdata[BW-1:0];
          3'd4: begin
            ctl_r    <= cfg_wdata[9:0];
            end_code <= 3'b000;
          end
          default: ;
        endcase
      end
      case (st)
        S_IDLE: begin
          if (stop_hit) begin
            end_code <= stop_code;
            ctl_r[0] <= 1'b0;
          end else if (ctl_r[0] && end_code == 3'b000 && req) begin
            wsrc  <= src_q;
            wdst  <= dst_q;
            wcnt  <= cnt_q;
            bcnt  <= '0;
            phase <= 1'b0;
            st    <= S_RUN;
          end
        end
        S_RUN: begin
          if (stop_hit) begin
            end_code <= stop_code;
            ctl_r[0] <= 1'b0;
            st       <= S_IDLE;
          end else if (acc_done) begin
            if (use_dst) wdst <= nxt(wdst, ctl_r[6:5], ctl_r[8:7]);
            else         wsrc <= nxt(wsrc, ctl_r[4:3], ctl_r[8:7]);
            if (!fly) phase <= ~phase;
            if (last_acc) bcnt <= bcnt + BW'(1);
            if (blk_end) st <= S_WB;
          end
        end
        default: begin
          src_q <= wsrc;
          dst_q <= wdst;
          if (cnt_next == '0) begin
            if (ctl_r[9]) cnt_q <= rld_r;
            else begin
              cnt_q    <= '0;
              end_code <= 3'b001;
              ctl_r[0] <= 1'b0;
            end
          end else begin
            cnt_q <= cnt_next;
          end
          st <= S_IDLE;
        end
      endcase
    end
  end
endmodule

module dma_chan_seq_chk #(
  parameter int AW = 32,
  parameter int CW = 16
) (
  input logic          clk,
  input logic          rst_n,
  input logic          cfg_we,
  input logic          sw_stop,
  input logic          acc_valid,
  input logic          acc_done,
  input logic [AW-1:0] acc_addr,
  input logic [AW-1:0] src_q,
  input logic [AW-1:0] dst_q,
  input logic [CW-1:0] cnt_q,
  input logic          chan_en,
  input logic [2:0]    end_code,
  input logic          busy
);
  AST_HOLD_ADDR: assert property (@(posedge clk) disable iff (!rst_n)
    acc_valid && $past(acc_valid) && !$past(acc_done) |-> $stable(acc_addr)); // R2
  AST_BOUNDARY_ONLY: assert property (@(posedge clk) disable iff (!rst_n)
    busy && $past(busy) && !$past(cfg_we) |-> $stable(src_q) && $stable(dst_q) && $stable(cnt_q)); // R4
  AST_DONE_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(end_code == 3'b001) |-> cnt_q == '0); // R7
  AST_SW_STOP: assert property (@(posedge clk) disable iff (!rst_n)
    $past(sw_stop) && $past(chan_en) && !$past(busy) |-> !chan_en && !busy); // R9
  AST_END_CLEARS_EN: assert property (@(posedge clk) disable iff (!rst_n)
    end_code != 3'b000 |-> !chan_en); // R7
  AST_NO_ACC_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> !acc_valid); // R10
endmodule

bind dma_chan_seq dma_chan_seq_chk #(.AW(AW), .CW(CW)) chk (.*);

// File: tb/dma_chan_seq_test.sv
module dma_chan_seq_test;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cfg_we = 1'b0;
  logic [2:0]  cfg_sel = '0;
  logic [31:0] cfg_wdata = '0;
  logic        req = 1'b0, ext_stop = 1'b0, sw_stop = 1'b0;
  logic        acc_done = 1'b1, acc_err = 1'b0;
  logic        acc_valid, acc_write, chan_en, busy;
  logic [31:0] acc_addr, src_q, dst_q;
  logic [1:0]  acc_size;
  logic [15:0] cnt_q;
  logic [2:0]  end_code;

  int nchk = 0, nbad = 0;
  logic [31:0] es, ed;
  logic [15:0] ec;

  always #2 clk = ~clk;

  dma_chan_seq uut (.*);

  task automatic ck(input string tag, input logic [31:0] act, input logic [31:0] exp);
    nchk++;
    if (act !== exp) begin
      nbad++;
      $display("FAIL %s act=%h exp=%h", tag, act, exp);
    end
  endtask

  function automatic logic [31:0] nxt(input logic [31:0] a, input int m, input int sz);
    logic [31:0] d;
    d = 32'd1 << sz;
    if (m == 1) return a + d;
    if (m == 2) return a - d;
    return a;
  endfunction

  function automatic logic [31:0] mkctl(input logic en, fly, wd, input int sm, dm, sz,
                                        input logic rl);
    return {22'd0, rl, sz[1:0], dm[1:0], sm[1:0], wd, fly, en};
  endfunction

  task automatic wr(input logic [2:0] sel, input logic [31:0] d);
    @(negedge clk);
    cfg_we = 1'b1; cfg_sel = sel; cfg_wdata = d;
    @(negedge clk);
    cfg_we = 1'b0;
  endtask

  task automatic setup(input logic [31:0] s, d, input logic [15:0] c, input int blk,
                       input logic [31:0] ctl);
    wr(3'd0, s); wr(3'd1, d); wr(3'd2, {16'd0, c}); wr(3'd3, blk); wr(3'd4, ctl);
    es = s; ed = d; ec = c;
  endtask

  task automatic run_block(input logic fly, wdir, input int sm, dm, sz, blk,
                           input logic rl, input logic [15:0] rld);
    logic [31:0] ws, wd;
    int tot;
    ws = es; wd = ed;
    tot = fly ? blk : 2 * blk;
    @(negedge clk); req = 1'b1;
    @(negedge clk); req = 1'b0;
    ck("R2 busy after request", busy, 1);
    for (int i = 0; i < tot; i++) begin
      if (i > 0) @(negedge clk);
      ck("R2 access valid", acc_valid, 1);
      ck("R4 source held mid-block", src_q, es);
      ck("R6 count held mid-block", cnt_q, ec);
      if (fly) begin
        ck("R5 fly-by address", acc_addr, wd);
        ck("R5 fly-by direction", acc_write, wdir);
        wd = nxt(wd, dm, sz);
      end else if (i % 2 == 0) begin
        ck("R2 read address", acc_addr, ws);
        ck("R2 read kind", acc_write, 0);
        ws = nxt(ws, sm, sz);
      end else begin
        ck("R3 write address", acc_addr, wd);
        ck("R2 write kind", acc_write, 1);
        wd = nxt(wd, dm, sz);
      end
    end
    @(negedge clk);
    ck("R4 write-back cycle no access", acc_valid, 0);
    ck("R4 destination still old", dst_q, ed);
    @(negedge clk);
    es = ws; ed = wd;
    if (ec == 16'd1) ec = rl ? rld : 16'd0;
    else ec = ec - 16'd1;
    ck("R4 source committed", src_q, es);
    ck("R4 destination committed", dst_q, ed);
    ck("R6 count committed", cnt_q, ec);
    ck("R4 idle after block", busy, 0);
  endtask

  task automatic no_start(input string tag);
    int seen;
    seen = 0;
    @(negedge clk); req = 1'b1;
    repeat (4) begin
      @(negedge clk);
      if (acc_valid) seen++;
    end
    req = 1'b0;
    ck(tag, seen, 0);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    nbad++;
    $display("FAIL watchdog act=hung exp=finished");
    $display("  test done: total=%0d bad=%0d", nchk, nbad);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    ck("R1 src reset", src_q, 0);
    ck("R1 dst reset", dst_q, 0);
    ck("R1 cnt reset", cnt_q, 0);
    ck("R1 end reset", end_code, 0);
    ck("R1 en reset", chan_en, 0);
    ck("R1 busy reset", busy, 0);
    ck("R1 no access", acc_valid, 0);

    for (int sz = 0; sz < 3; sz++)
      for (int sm = 0; sm < 3; sm++)
        for (int dm = 0; dm < 3; dm++) begin
          setup(32'hFFFF_FFF8, 32'h0000_0004, 16'd2, 3, mkctl(1, 0, 0, sm, dm, sz, 0));
          run_block(0, 0, sm, dm, sz, 3, 0, 0);
          ck("R6 channel still enabled", chan_en, 1);
          run_block(0, 0, sm, dm, sz, 3, 0, 0);
          ck("R7 end code complete", end_code, 3'b001);
          ck("R7 enable cleared", chan_en, 0);
          no_start("R10 no start after end");
        end

    for (int wd = 0; wd < 2; wd++)
      for (int dm = 0; dm < 3; dm++) begin
        setup(32'h1234_5670, 32'hFFFF_FFF0, 16'd1, 5, mkctl(1, 1, wd[0], 1, dm, 2, 0));
        run_block(1, wd[0], 1, dm, 2, 5, 0, 0);
        ck("R5 source untouched", src_q, 32'h1234_5670);
        ck("R7 fly-by end code", end_code, 3'b001);
      end

    setup(32'h100, 32'h200, 16'd2, 2, mkctl(1, 0, 0, 1, 1, 1, 1));
    run_block(0, 0, 1, 1, 1, 2, 1, 16'd2);
    run_block(0, 0, 1, 1, 1, 2, 1, 16'd2);
    ck("R8 count reloaded", cnt_q, 2);
    ck("R8 end code zero", end_code, 0);
    ck("R8 enable kept", chan_en, 1);
    run_block(0, 0, 1, 1, 1, 2, 1, 16'd2);
    ck("R8 rearmed run", cnt_q, 1);

    wr(3'd4, mkctl(0, 0, 0, 1, 1, 0, 0));
    no_start("R10 disabled channel ignores request");

    setup(32'h40, 32'h80, 16'd3, 4, mkctl(1, 0, 0, 1, 1, 0, 0));
    acc_done = 1'b0;
    @(negedge clk); req = 1'b1;
    @(negedge clk); req = 1'b0;
    ck("R9 stalled access", acc_valid, 1);
    ext_stop = 1'b1;
    @(negedge clk); ext_stop = 1'b0;
    ck("R9 ext stop code", end_code, 3'b011);
    ck("R9 ext stop clears enable", chan_en, 0);
    ck("R9 no access after stop", acc_valid, 0);
    ck("R9 no write-back", cnt_q, 3);

    wr(3'd4, mkctl(1, 0, 0, 1, 1, 0, 0));
    ck("R10 control write clears code", end_code, 0);
    @(negedge clk); req = 1'b1;
    @(negedge clk); req = 1'b0;
    ext_stop = 1'b1; sw_stop = 1'b1;
    @(negedge clk); ext_stop = 1'b0; sw_stop = 1'b0;
    ck("R9 ext over sw priority", end_code, 3'b011);

    wr(3'd4, mkctl(1, 0, 0, 1, 1, 0, 0));
    @(negedge clk); req = 1'b1;
    @(negedge clk); req = 1'b0;
    acc_done = 1'b1; acc_err = 1'b1; ext_stop = 1'b1;
    @(negedge clk); acc_err = 1'b0; ext_stop = 1'b0;
    ck("R9 error over ext priority", end_code, 3'b010);
    ck("R9 error clears enable", chan_en, 0);

    wr(3'd4, mkctl(1, 0, 0, 1, 1, 0, 0));
    @(negedge clk); sw_stop = 1'b1;
    @(negedge clk); sw_stop = 1'b0;
    ck("R9 sw stop code", end_code, 3'b100);
    ck("R9 sw stop clears enable", chan_en, 0);
    no_start("R10 no start after stop");

    $display("  test done: total=%0d bad=%0d", nchk, nbad);
    $finish;
  end
endmodule